// File: doc/BRIEF.md
# UART Interrupt Mask and Line Router

This block keeps the raw interrupt status of a UART and the interrupt mask that selects which status bits reach the interrupt pins. Each cycle, per-source set pulses arrive from the receive buffer, the transmit path, the receive-timeout counter, the modem-status logic and the error detector. A separate pulse marks every write to the UART data register. Software reaches the block through a small register port. A 2-bit select picks one of four views: the mask, the raw status, the masked status or the clear register. A write strobe and write data apply to the selected view.

The masked vector is the raw status ANDed with the mask. It drives six interrupt lines: one combined line that covers every source, and five lines for the receive, transmit, receive-timeout, modem-status and error groups. The lines come from state through gates only. A change to the mask or to the status is therefore visible on the pins in the cycle right after the clock edge that stores it.

Top module: `uart_irq_router`

## Requirements
- R1: While reset is held and after it is released, the mask and the raw status are zero, every read view returns zero and all six lines are low.
- R2: A write with select 0 (mask view) stores the write data as the mask. A read with select 0 returns the stored mask.
- R3: A set pulse on bit i of `evt_set` makes raw bit i one from the next cycle on. The bit then stays set until it is cleared. Select 1 reads the raw status. Status bit layout: 0 ring indicator, 1 clear-to-send, 2 carrier detect, 3 data-set-ready, 4 receive, 5 transmit, 6 receive timeout, 7 framing error, 8 parity error, 9 break error, 10 overrun error.
- R4: A read with select 2 returns the raw status ANDed with the mask.
- R5: A write with select 3 (clear view) clears every raw bit written as one and leaves the bits written as zero unchanged.
- R6: A read with select 3 always returns zero.
- R7: Writes with select 1 or select 2 change neither the raw status nor the mask.
- R8: A `data_wr` pulse sets raw bit 5 (transmit) in the next cycle, whatever else happens in that cycle.
- R9: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R10: `irq_rx`, `irq_tx` and `irq_rtim` follow masked bits 4, 5 and 6. `irq_modem` is the OR of masked bits 0 to 3. `irq_err` is the OR of masked bits 7 to 10.
- R11: `irq_all` is high exactly when any masked bit is set.
- R12: A mask write changes the lines in the cycle right after the write edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | View select: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_we | input | 1 | Write strobe for the selected view |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 11 | Read data of the selected view (combinational) |
| evt_set | input | 11 | Per-source set pulses, status bit layout |
| data_wr | input | 1 | Pulse for a data register write; sets the transmit bit |
| irq_all | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rtim | output | 1 | Receive timeout interrupt line |
| irq_modem | output | 1 | Modem status interrupt line |
| irq_err | output | 1 | Error interrupt line |

## Verification
Read data reflects the current state and select with no delay. Every write, set pulse or data-write pulse shows up one clock later: the raw and mask registers load on that edge, and the read data and lines follow it through gates only. The bench drives each stimulus on a falling edge and holds it through one rising edge. It then drops the strobes on the next falling edge and compares the read data and all six lines against its own model, stepped once for that rising edge. Directed steps, for example a clear that collides with a set or a mask written to zero, are checked in the same slot.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IRQ_W = 11;
  localparam int NLINE = 6;

  localparam int B_RI  = 0;
  localparam int B_CTS = 1;
  localparam int B_DCD = 2;
  localparam int B_DSR = 3;
  localparam int B_RX  = 4;
  localparam int B_TX  = 5;
  localparam int B_RT  = 6;
  localparam int B_FE  = 7;
  localparam int B_PE  = 8;
  localparam int B_BE  = 9;
  localparam int B_OE  = 10;

  localparam int L_ALL = 0;
  localparam int L_RX  = 1;
  localparam int L_TX  = 2;
  localparam int L_RT  = 3;
  localparam int L_MS  = 4;
  localparam int L_ERR = 5;

  typedef logic [IRQ_W-1:0] irq_vec_t;

  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_MASKED = 2'd2,
    SEL_CLEAR  = 2'd3
  } irq_sel_e;

  // Status bits that feed a given output line.
  function automatic irq_vec_t line_group(input int idx);
    irq_vec_t g;
    g = '0;
    case (idx)
      L_ALL: g = '1;
      L_RX:  g[B_RX] = 1'b1;
      L_TX:  g[B_TX] = 1'b1;
      L_RT:  g[B_RT] = 1'b1;
      L_MS:  g[B_DSR:B_RI] = '1;
      L_ERR: g[B_OE:B_FE] = '1;
      default: g = '0;
    endcase
    return g;
  endfunction

  // Write-one-to-clear, with set requests taking priority.
  function automatic irq_vec_t next_raw(input irq_vec_t raw, input irq_vec_t clr,
                                        input irq_vec_t set);
    return (raw & ~clr) | set;
  endfunction
endpackage

// File: rtl/irq_raw_status.sv
module irq_raw_status
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t set_vec,
  input  irq_vec_t clr_vec,
  output irq_vec_t raw
);
  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else        raw <= next_raw(raw, clr_vec, set_vec);
  end

  // R5: a cleared bit without a competing set reads zero next cycle
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((raw & $past(clr_vec & ~set_vec)) == '0));

  // R9: set requests always land, even under a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((raw & $past(set_vec)) == $past(set_vec)));

  // R3: status holds without set or clear
  p_raw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(raw));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  irq_vec_t wdata,
  output irq_vec_t mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mask <= '0;
    else if (we) mask <= wdata;
  end

  // R7: mask only moves on its own write
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask));
endmodule

// File: rtl/irq_line_fanout.sv
module irq_line_fanout
  import uart_irq_pkg::*;
(
  input  irq_vec_t         masked,
  output logic [NLINE-1:0] lines
);
  for (genvar g = 0; g < NLINE; g++) begin : g_line
    localparam irq_vec_t GRP = line_group(g);
    assign lines[g] = |(masked & GRP);
  end
endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_we,
  input  logic [10:0] reg_wdata,
  output logic [10:0] reg_rdata,
  input  logic [10:0] evt_set,
  input  logic        data_wr,
  output logic        irq_all,
  output logic        irq_rx,
  output logic        irq_tx,
  output logic        irq_rtim,
  output logic        irq_modem,
  output logic        irq_err
);
  irq_vec_t raw, mask, masked, clr_vec, set_vec;
  logic [NLINE-1:0] lines;
  logic mask_we, clr_we;

  assign mask_we = reg_we && (reg_sel == SEL_MASK);
  assign clr_we  = reg_we && (reg_sel == SEL_CLEAR);
  assign clr_vec = clr_we ? reg_wdata : '0;
  assign set_vec = evt_set | (irq_vec_t'(data_wr) << B_TX);
  assign masked  = raw & mask;

  irq_raw_status u_raw (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .raw(raw)
  );

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(reg_wdata), .mask(mask)
  );

  irq_line_fanout u_fan (.masked(masked), .lines(lines));

  always_comb begin
    case (reg_sel)
      SEL_MASK:   reg_rdata = mask;
      SEL_RAW:    reg_rdata = raw;
      SEL_MASKED: reg_rdata = masked;
      default:    reg_rdata = '0;
    endcase
  end

  assign irq_all   = lines[L_ALL];
  assign irq_rx    = lines[L_RX];
  assign irq_tx    = lines[L_TX];
  assign irq_rtim  = lines[L_RT];
  assign irq_modem = lines[L_MS];
  assign irq_err   = lines[L_ERR];

  // R11: combined line agrees with the group lines
  p_all_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_all == (irq_rx | irq_tx | irq_rtim | irq_modem | irq_err));

  // R8: data register write always raises the transmit status
  p_tx_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> raw[B_TX]);

  // R12: a zero mask silences every line on the next cycle
  p_mask_reval_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && reg_wdata == '0) |=> !irq_all);

  // R6: clear view reads zero
  p_clear_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_CLEAR) |-> (reg_rdata == '0));
endmodule

// File: tb/tb_uart_irq_router.sv
module tb_uart_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic reg_we = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] evt_set = '0;
  logic data_wr = 1'b0;
  logic irq_all, irq_rx, irq_tx, irq_rtim, irq_modem, irq_err;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_raw = '0;
  logic [W-1:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_router dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .data_wr(data_wr), .irq_all(irq_all), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_rtim(irq_rtim), .irq_modem(irq_modem), .irq_err(irq_err)
  );

  function automatic logic [W-1:0] exp_read(input logic [1:0] s);
    case (s)
      2'd0: return m_mask;
      2'd1: return m_raw;
      2'd2: return m_raw & m_mask;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] mk;
    mk = m_raw & m_mask;
    chk({tag, " read"}, reg_rdata, exp_read(reg_sel));
    chk({tag, " R10 rx"}, W'(irq_rx), W'(mk[4]));
    chk({tag, " R10 tx"}, W'(irq_tx), W'(mk[5]));
    chk({tag, " R10 rtim"}, W'(irq_rtim), W'(mk[6]));
    chk({tag, " R10 modem"}, W'(irq_modem), W'(mk[0] | mk[1] | mk[2] | mk[3]));
    chk({tag, " R10 err"}, W'(irq_err), W'(mk[7] | mk[8] | mk[9] | mk[10]));
    chk({tag, " R11 all"}, W'(irq_all), W'(mk != '0));
  endtask

  // One register-port cycle; model steps at the rising edge, check after it.
  task automatic cyc(input logic [1:0] s, input logic w, input logic [W-1:0] d,
                     input logic [W-1:0] e, input logic dw, input string tag);
    reg_sel = s; reg_we = w; reg_wdata = d; evt_set = e; data_wr = dw;
    @(posedge clk);
    for (int i = 0; i < W; i++) begin
      logic setb, clrb;
      setb = e[i] || (dw && i == 5);
      clrb = w && s == 2'd3 && d[i];
      if (setb) m_raw[i] = 1'b1;
      else if (clrb) m_raw[i] = 1'b0;
    end
    if (w && s == 2'd0) m_mask = d;
    @(negedge clk);
    reg_we = 1'b0; evt_set = '0; data_wr = 1'b0;
    #1 check_all(tag);
  endtask

  task automatic peek(input logic [1:0] s, input string tag);
    reg_sel = s;
    #1 chk(tag, reg_rdata, exp_read(s));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: state under reset
    #1 check_all("R1 in-reset");
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_all("R1 after-reset");
    peek(2'd1, "R1 raw zero");
    peek(2'd2, "R1 masked zero");

    // R2: mask write and readback
    cyc(2'd0, 1'b1, 11'h5A5, '0, 1'b0, "R2 mask write");
    // R3: set pulses accumulate
    cyc(2'd1, 1'b0, '0, 11'h003, 1'b0, "R3 set modem");
    cyc(2'd1, 1'b0, '0, 11'h480, 1'b0, "R3 set errors");
    // R4: masked view
    peek(2'd2, "R4 masked read");
    // R7: writes to raw and masked views ignored
    cyc(2'd1, 1'b1, 11'h7FF, '0, 1'b0, "R7 raw write");
    cyc(2'd2, 1'b1, 11'h000, '0, 1'b0, "R7 masked write");
    peek(2'd0, "R7 mask intact");
    // R5: partial clear
    cyc(2'd3, 1'b1, 11'h401, '0, 1'b0, "R5 clear some");
    peek(2'd1, "R5 remaining bits");
    // R6: clear view reads zero with status pending
    peek(2'd3, "R6 clear reads zero");
    // R8: data write sets TX with mask exposing it
    cyc(2'd0, 1'b1, 11'h020, '0, 1'b0, "R12 mask tx only");
    cyc(2'd1, 1'b0, '0, '0, 1'b1, "R8 data write");
    // R9: set and clear collide on the same bit
    cyc(2'd3, 1'b1, 11'h7FF, 11'h010, 1'b0, "R9 set beats clear");
    peek(2'd1, "R9 raw after collision");
    cyc(2'd3, 1'b1, 11'h7FF, '0, 1'b1, "R9 data write beats clear");
    // R12: mask changes lines right away
    cyc(2'd0, 1'b1, 11'h7FF, '0, 1'b0, "R12 mask all");
    cyc(2'd0, 1'b1, 11'h000, '0, 1'b0, "R12 mask none");
    cyc(2'd0, 1'b1, 11'h780, 11'h780, 1'b0, "R10 error group");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] s;
      logic w, dw;
      logic [W-1:0] d, e;
      s  = 2'($urandom);
      w  = 1'($urandom);
      d  = W'($urandom);
      e  = W'($urandom) & W'($urandom) & W'($urandom);
      dw = (($urandom % 8) == 0);
      cyc(s, w, d, e, dw, "R3 random");
      peek(2'($urandom), "R4 random view");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule